// File: doc/BRIEF.md
# SONET Byte-Alignment Framer

This block takes a bit-serial SONET/SDH line, one bit per clock with the most significant bit of each byte first. It packs the bits into bytes and hands out one byte every eight clocks. The byte boundary is chosen by the rotation select: the block compares the last fifteen received bits against the framing pattern at all eight bit offsets at once. The framing pattern is three A1 bytes followed by three A2 bytes. Each time that pattern shows up at the current boundary, a sync flag rides along with the byte that completes it.

The boundary moves only through a hunt. A hunt is armed by a rising edge on the out-of-frame input, and it ends at the first byte beat on which some offset completes the pattern. The lowest such offset is then frozen. Seeing the pattern again at another offset never moves the boundary by itself. A recovery-disable input vetoes hunts, and a synchronous reset returns the block to offset zero.

The parallel side is a valid-only stream. `byte_valid` pulses for one clock per byte. `byte_out` and `sync_out` hold their values until the next pulse. There is no ready input: the serial line cannot be stalled, so the consumer must accept every beat. The serial input carries no valid and is taken on every clock.

Top module: `sonet_byte_framer`

## Requirements
- R1: After reset is released, `byte_valid` is high for one clock on every eighth clock. The first pulse follows the eighth serial bit. A relock never shortens or lengthens this cadence.
- R2: The byte given on a beat holds eight consecutive received bits. The earliest of them lands in bit 7 and the latest in bit 0 (the LSB). `byte_out` holds its value between beats.
- R3: `sync_out` is high for exactly the one beat period whose byte is the third A2 of an A1,A1,A1,A2,A2,A2 run at the current boundary. This puts it two beats after the beat that delivered the first A2. It behaves this way whatever the level of `oof`.
- R4: A low-to-high change of `oof` arms a hunt. A high level of `oof`, including a level already high when reset is released, does not arm one.
- R5: During a hunt, the first beat on which any offset completes the pattern freezes the lowest such offset. The byte and the sync flag of that same beat are already taken at the new boundary.
- R6: With no hunt armed, the boundary stays put. The pattern arriving at another offset raises no sync, and bytes keep the old boundary.
- R7: While `recov_dis` is high, `oof` edges arm nothing and any armed hunt is dropped. The boundary stays put.
- R8: If an `oof` rising edge falls on the same clock as a beat that completes a hunt, the lock is applied, and the hunt also stays armed for the next matching frame.
- R9: Synchronous `rst` clears the bit counter, the bit history, the pattern trackers and all outputs, selects offset zero and disarms the hunt.
- R10: A1 is 8'hF6 and A2 is 8'h28 (defaults of the pattern parameters).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial line data, byte MSB first |
| oof | input | 1 | Out-of-frame; rising edge arms a boundary hunt |
| recov_dis | input | 1 | High vetoes and cancels boundary hunts |
| byte_valid | output | 1 | One-clock pulse per delivered byte, no back-pressure |
| byte_out | output | 8 | Aligned byte, bit 0 is the last bit received |
| sync_out | output | 1 | High for the beat period carrying the third A2 |

## Verification
The two events that can meet on one clock are a hunt completing on a byte beat and a fresh `oof` rising edge. The bench builds a stream with a hunt pending. It computes the exact clock on which the third A2 is delivered at the winning offset, and it raises `oof` on precisely that clock. The result is judged on the following frame, which is shifted by two bits with no further edge. The bytes and sync must follow the shifted frame, which happens only if the edge kept the hunt armed while the lock was still applied. In the other scenarios, every byte, every sync value and every beat position is compared against a model of the stimulus across all eight starting offsets.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int BYTE_W_DEF = 8;
  localparam int RUN_LEN_DEF = 3;
  localparam logic [7:0] A1_DEF = 8'hF6;
  localparam logic [7:0] A2_DEF = 8'h28;

  typedef enum logic {
    ALIGN_HELD = 1'b0,
    ALIGN_HUNT = 1'b1
  } align_mode_e;
endpackage

// File: rtl/frm_lane.sv
// Pattern tracker for one bit offset: counts an A1 run then an A2 run.
module frm_lane #(
  parameter int BYTE_W = 8,
  parameter int RUN_LEN = 3,
  parameter logic [BYTE_W-1:0] A1_CODE = 8'hF6,
  parameter logic [BYTE_W-1:0] A2_CODE = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [BYTE_W-1:0] cand,
  output logic              hit
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] a1_run;
  logic [RUN_W-1:0] a2_run;
  logic is_a1;
  logic is_a2;
  logic a1_full;

  assign is_a1   = (cand == A1_CODE);
  assign is_a2   = (cand == A2_CODE);
  assign a1_full = (a1_run == RUN_W'(RUN_LEN));
  assign hit     = is_a2 && a1_full && (a2_run == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a1_run <= '0;
      a2_run <= '0;
    end else if (step) begin
      if (hit) begin
        a1_run <= '0;
        a2_run <= '0;
      end else if (is_a1) begin
        a2_run <= '0;
        if (a2_run != '0) a1_run <= RUN_W'(1);
        else if (!a1_full) a1_run <= a1_run + 1'b1;
      end else if (is_a2 && a1_full) begin
        a2_run <= a2_run + 1'b1;
      end else begin
        a1_run <= '0;
        a2_run <= '0;
      end
    end
  end
endmodule

// File: rtl/frm_pick.sv
// Lowest-index priority select over the lane hit vector.
module frm_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/frm_srch_ctl.sv
// Hunt arming: OOF edge detect, disable veto, lock completion.
module frm_srch_ctl
  import frm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oof,
  input  logic recov_dis,
  input  logic lock,
  output logic searching
);
  align_mode_e mode;
  logic oof_q;
  logic oof_rise;

  assign oof_rise  = oof && !oof_q;
  assign searching = (mode == ALIGN_HUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      oof_q <= 1'b1;
      mode  <= ALIGN_HELD;
    end else begin
      oof_q <= oof;
      if (recov_dis)     mode <= ALIGN_HELD;
      else if (oof_rise) mode <= ALIGN_HUNT;
      else if (lock)     mode <= ALIGN_HELD;
    end
  end
endmodule

// File: rtl/sonet_byte_framer.sv
module sonet_byte_framer #(
  parameter int BYTE_W = frm_pkg::BYTE_W_DEF,
  parameter int RUN_LEN = frm_pkg::RUN_LEN_DEF,
  parameter logic [BYTE_W-1:0] A1_CODE = frm_pkg::A1_DEF,
  parameter logic [BYTE_W-1:0] A2_CODE = frm_pkg::A2_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              oof,
  input  logic              recov_dis,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              sync_out
);
  localparam int ROT_N = BYTE_W;
  localparam int ROT_W = $clog2(ROT_N);
  localparam int WIN_W = 2 * BYTE_W - 1;
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WIN_W-2:0]  hist;
  logic [WIN_W-1:0]  win;
  logic              tick;
  logic [BYTE_W-1:0] cand [ROT_N];
  logic [ROT_N-1:0]  hits;
  logic              hit_any;
  logic [ROT_W-1:0]  hit_first;
  logic [ROT_W-1:0]  rot_q;
  logic [ROT_W-1:0]  rot_sel;
  logic              searching;
  logic              lock;

  assign win  = {hist, ser_in};
  assign tick = (bit_cnt == CNT_W'(BYTE_W - 1));

  for (genvar k = 0; k < ROT_N; k++) begin : g_lane
    assign cand[k] = win[k +: BYTE_W];
    frm_lane #(
      .BYTE_W (BYTE_W),
      .RUN_LEN(RUN_LEN),
      .A1_CODE(A1_CODE),
      .A2_CODE(A2_CODE)
    ) u_lane (
      .clk (clk),
      .rst (rst),
      .step(tick),
      .cand(cand[k]),
      .hit (hits[k])
    );
  end

  frm_pick #(.N(ROT_N)) u_pick (
    .hits(hits),
    .any (hit_any),
    .idx (hit_first)
  );

  frm_srch_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .oof      (oof),
    .recov_dis(recov_dis),
    .lock     (lock),
    .searching(searching)
  );

  assign lock    = tick && searching && hit_any;
  assign rot_sel = lock ? hit_first : rot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      hist       <= '0;
      rot_q      <= '0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
      sync_out   <= 1'b0;
    end else begin
      bit_cnt    <= tick ? '0 : bit_cnt + 1'b1;
      hist       <= win[WIN_W-2:0];
      byte_valid <= tick;
      if (tick) begin
        byte_out <= cand[rot_sel];
        sync_out <= hits[rot_sel];
        rot_q    <= rot_sel;
      end
    end
  end
endmodule

// File: rtl/frm_chk.sv
module frm_chk #(
  parameter int BYTE_W = 8,
  localparam int ROT_W = $clog2(BYTE_W),
  localparam int GAP_W = $clog2(BYTE_W + 2) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              oof,
  input logic              recov_dis,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_out,
  input logic              sync_out,
  input logic              srch,
  input logic [ROT_W-1:0]  rot
);
  logic armed;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    armed <= !rst;
    if (rst) gap <= '0;
    else if (byte_valid) gap <= GAP_W'(1);
    else if (gap != '1) gap <= gap + 1'b1;
  end

  a_r1_beat_spacing: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> (gap == GAP_W'(BYTE_W)));

  a_r2_byte_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !byte_valid) |-> $stable(byte_out));

  a_r3_sync_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !byte_valid) |-> $stable(sync_out));

  a_r4_edge_arms: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(oof) && !recov_dis) |=> srch);

  a_r5_move_with_sync: assert property (@(posedge clk) disable iff (rst)
    (armed && !$stable(rot)) |-> (sync_out && byte_valid));

  a_r6_rot_frozen: assert property (@(posedge clk) disable iff (rst)
    (armed && !srch) |=> $stable(rot));

  a_r7_disable_drops: assert property (@(posedge clk) disable iff (rst)
    recov_dis |=> !srch);
endmodule

bind sonet_byte_framer frm_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .oof       (oof),
  .recov_dis (recov_dis),
  .byte_valid(byte_valid),
  .byte_out  (byte_out),
  .sync_out  (sync_out),
  .srch      (searching),
  .rot       (rot_q)
);

// File: tb/sim_sonet_byte_framer.sv
module sim_sonet_byte_framer;
  localparam int MAXB = 2048;
  localparam logic [7:0] A1 = 8'hF6;
  localparam logic [7:0] A2 = 8'h28;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic oof = 1'b0;
  logic recov_dis = 1'b0;
  logic byte_valid;
  logic [7:0] byte_out;
  logic sync_out;

  sonet_byte_framer u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .oof(oof), .recov_dis(recov_dis),
    .byte_valid(byte_valid), .byte_out(byte_out), .sync_out(sync_out)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic strm  [MAXB];
  logic oofv  [MAXB];
  logic disv  [MAXB];
  logic isend [MAXB];
  byte  ptag  [MAXB];
  int   len;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagname(input byte c);
    case (c)
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < MAXB; i++) begin
      strm[i] = 0; oofv[i] = 0; disv[i] = 0; isend[i] = 0; ptag[i] = 0;
    end
    len = 0;
  endtask

  task automatic push_bit(input logic b, input logic o, input logic d, input byte t);
    if (len < MAXB) begin
      strm[len] = b; oofv[len] = o; disv[len] = d; ptag[len] = t;
      len = len + 1;
    end
  endtask

  task automatic push_byte(input logic [7:0] v, input logic o, input logic d, input byte t);
    for (int i = 7; i >= 0; i--) push_bit(v[i], o, d, t);
  endtask

  task automatic push_gap(input int n, input logic o, input logic d, input byte t);
    for (int i = 0; i < n; i++) push_bit(1'b0, o, d, t);
  endtask

  // R10: framing bytes F6,F6,F6,28,28,28 then ten payload bytes
  task automatic push_frame(input logic o, input logic d, input byte t);
    for (int i = 0; i < 3; i++) push_byte(A1, o, d, t);
    for (int i = 0; i < 3; i++) push_byte(A2, o, d, t);
    isend[len-1] = 1;
    for (int j = 0; j < 10; j++) push_byte(8'(8'h40 + j), o, d, t);
  endtask

  task automatic run(input logic reset_oof);
    int  m_rot;
    bit  m_srch;
    logic oprev;
    @(negedge clk);
    rst = 1; oof = reset_oof; recov_dis = 0; ser_in = 0;
    repeat (3) @(negedge clk);
    chk(byte_valid == 1'b0, "R9", "valid after reset", int'(byte_valid), 0);
    chk(byte_out == 8'h00, "R9", "byte after reset", int'(byte_out), 0);
    chk(sync_out == 1'b0, "R9", "sync after reset", int'(sync_out), 0);
    m_rot = 0; m_srch = 0; oprev = 1;
    rst = 0;
    for (int n = 0; n < len; n++) begin
      bit tick, lock, rise, exp_sync;
      int r_used;
      logic [7:0] exp_b;
      ser_in = strm[n]; oof = oofv[n]; recov_dis = disv[n];
      @(negedge clk);
      tick = ((n % 8) == 7);
      lock = 0;
      r_used = m_rot;
      if (tick && m_srch) begin
        for (int r = 0; r < 8; r++) begin
          if (!lock && (n - r) >= 0 && isend[n-r]) begin
            lock = 1; r_used = r;
          end
        end
      end
      chk(byte_valid == tick, "R1", "beat position", int'(byte_valid), int'(tick));
      if (tick) begin
        for (int i = 0; i < 8; i++) begin
          int idx;
          idx = n - r_used - i;
          exp_b[i] = (idx >= 0) ? strm[idx] : 1'b0;
        end
        exp_sync = ((n - r_used) >= 0) && isend[n-r_used];
        chk(byte_out == exp_b, lock ? "R5" : tagname(ptag[n]), "byte",
            int'(byte_out), int'(exp_b));
        chk(sync_out == exp_sync, lock ? "R5" : "R3/R10", "sync",
            int'(sync_out), int'(exp_sync));
      end
      m_rot = r_used;
      rise = oofv[n] && !oprev;
      if (disv[n]) m_srch = 0;
      else if (rise) m_srch = 1;
      else if (lock) m_srch = 0;
      oprev = oofv[n];
    end
  endtask

  initial begin
    // sweep: every start offset, boundary hold, relock, disable veto
    for (int off = 0; off < 8; off++) begin
      int d;
      d = 1 + ((off * 5) % 7);
      clear_stim();
      push_gap(16 + off, 0, 0, 0);
      push_gap(16, 1, 0, 1);
      push_frame(0, 0, 1);
      push_frame(0, 0, 0);
      push_gap(d, 0, 0, 2);
      push_frame(0, 0, 2);
      push_frame(0, 0, 2);
      push_gap(16, 1, 0, 1);
      push_frame(0, 0, 1);
      push_frame(0, 0, 0);
      push_gap(3, 0, 1, 3);
      push_gap(16, 1, 1, 3);
      push_frame(0, 1, 3);
      push_frame(0, 1, 3);
      push_gap(8, 0, 0, 3);
      run(0);
    end
    // special: OOF high through reset release, then edge on the lock beat (R8)
    begin
      int e, nl;
      clear_stim();
      push_gap(5, 1, 0, 1);
      push_frame(1, 0, 1);
      push_gap(16, 0, 0, 1);
      push_gap(16, 1, 0, 1);
      push_gap(8, 0, 0, 1);
      push_frame(0, 0, 4);
      e = len - 1 - 80;
      nl = e + ((7 - (e % 8) + 8) % 8);
      for (int i = 0; i < 16; i++) oofv[nl + i] = 1;
      push_gap(2, 0, 0, 4);
      push_frame(0, 0, 4);
      push_frame(0, 0, 4);
      run(1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule